// File: doc/BRIEF.md
# Bridge Posted Write Buffer

This block carries the write data of one direction of a bus bridge. A source master offers write words on a valid/ready interface, each word tagged with a flag that marks the end of its burst. A target drains the words on a second valid/ready interface. A run-time control input selects between two ways of working.

With posting on, the block is a decoupling FIFO. Words are taken as long as there is room, and the source is told its burst is complete as soon as the final word is stored. With posting off, the block is a lock-step pass-through. It first lets the buffer empty. After that it holds at most one word at a time, and it reports completion only once the target has consumed the final word.

A new setting of the control input is adopted only between bursts and with the buffer empty. A burst therefore never straddles two modes, and words of an earlier mode never overtake those of the next.

Top module: `wpost_buf`

## Requirements
- R1: While reset is held and in the first cycle after it is released, posting mode is active, `src_ready_o` is 1, `tgt_valid_o` is 0 and `done_o` is 0.
- R2: In posting mode a source word is accepted whenever fewer than DEPTH words are stored, regardless of `tgt_ready_i`; with DEPTH words stored `src_ready_o` is 0.
- R3: In posting mode, `done_o` is high for exactly the one cycle that follows the acceptance of a source word whose `src_last_i` is 1, whether or not the target has taken it.
- R4: Words leave on `tgt_data_o` in the order they were accepted, each with its own last flag on `tgt_last_o`, and `tgt_valid_o` is 1 exactly when at least one word is stored.
- R5: In pass-through mode a source word is accepted only when the buffer is empty, so a word is taken only after the target has consumed the previous one, and at most one word is ever stored.
- R6: In pass-through mode, `done_o` is high for exactly the one cycle that follows the target's acceptance of a word whose last flag is 1. Acceptance of that word at the source raises no pulse.
- R7: The value of `post_en_i` is adopted only in a cycle where no burst is partly accepted, the buffer is empty and no word is being accepted. Otherwise the previous mode stays in force.
- R8: `done_o` pulses once per burst and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_en_i | input | 1 | Requested mode: 1 posting, 0 pass-through |
| src_valid_i | input | 1 | Source word valid |
| src_ready_o | output | 1 | Block can accept a source word |
| src_data_i | input | W | Source write word |
| src_last_i | input | 1 | Word ends its burst |
| done_o | output | 1 | One-cycle burst completion pulse to the source |
| tgt_valid_o | output | 1 | A stored word is offered to the target |
| tgt_ready_i | input | 1 | Target takes the offered word |
| tgt_data_o | output | W | Offered write word |
| tgt_last_o | output | 1 | Offered word ends its burst |

## Verification
Posting traffic runs against a stalled target until the buffer fills. This separates a correct full threshold from an early or late one, and shows whether completion waits on the target. Pass-through traffic runs with a randomly throttled target, which exposes any second word taken before the first is drained and any completion pulse raised at the source side. A stream that flips `post_en_i` at random, bursts of one to five words included, checks that modes only switch at empty burst boundaries. Bursts that would otherwise straddle the switch catch a change adopted too early.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    typedef enum logic {
        MODE_THRU = 1'b0,
        MODE_POST = 1'b1
    } wmode_e;

    // handshake events seen by the completion unit
    typedef struct packed {
        logic push;
        logic push_last;
        logic pop;
        logic pop_hold;
    } xfer_t;

    function automatic int unsigned cnt_bits(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

    function automatic int unsigned ptr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/wpb_fifo.sv
module wpb_fifo
    import wpb_pkg::*;
#(
    parameter int unsigned DW    = 34,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW   = cnt_bits(DEPTH),
    localparam int unsigned AW   = ptr_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count
);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign dout = mem[rd_ptr];

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        push |-> (count != CW'(DEPTH)));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

endmodule

// File: rtl/wpb_mode_ctl.sv
module wpb_mode_ctl
    import wpb_pkg::*;
#(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          post_en_i,
    input  logic          push,
    input  logic          push_last,
    input  logic [CW-1:0] count,
    output wmode_e        mode,
    output logic          in_burst
);
    logic switch_ok;

    // a burst boundary with nothing stored and nothing arriving
    assign switch_ok = !in_burst && (count == '0) && !push;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_POST;
            in_burst <= 1'b0;
        end else begin
            if (switch_ok) mode <= post_en_i ? MODE_POST : MODE_THRU;
            if (push)      in_burst <= !push_last;
        end
    end

    p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
        in_burst |=> $stable(mode));

    p_mode_hold_full_r7: assert property (@(posedge clk) disable iff (rst)
        (count != '0) |=> $stable(mode));

endmodule

// File: rtl/wpb_done.sv
module wpb_done
    import wpb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  wmode_e mode,
    input  xfer_t  xf,
    output logic   done_o
);
    logic post_done, thru_done;

    assign post_done = xf.push && xf.push_last && (mode == MODE_POST);
    assign thru_done = xf.pop && xf.pop_hold;

    always_ff @(posedge clk) begin
        if (rst) done_o <= 1'b0;
        else     done_o <= post_done || thru_done;
    end

    p_done_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(post_done && thru_done));

    p_thru_done_r6: assert property (@(posedge clk) disable iff (rst)
        (xf.pop && xf.pop_hold) |=> done_o);

endmodule

// File: rtl/wpost_buf.sv
module wpost_buf
    import wpb_pkg::*;
#(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         post_en_i,
    input  logic         src_valid_i,
    output logic         src_ready_o,
    input  logic [W-1:0] src_data_i,
    input  logic         src_last_i,
    output logic         done_o,
    output logic         tgt_valid_o,
    input  logic         tgt_ready_i,
    output logic [W-1:0] tgt_data_o,
    output logic         tgt_last_o
);
    localparam int unsigned CW = cnt_bits(DEPTH);

    typedef struct packed {
        logic         hold;   // completion waits for the target
        logic         last;
        logic [W-1:0] data;
    } entry_t;

    localparam int unsigned EW = $bits(entry_t);

    wmode_e        mode;
    logic          in_burst;
    logic [CW-1:0] count;
    logic          push, pop;
    entry_t        wr_ent, rd_ent;
    xfer_t         xf;

    always_comb begin
        if (mode == MODE_POST) src_ready_o = (count != CW'(DEPTH));
        else                   src_ready_o = (count == '0);
    end

    assign push        = src_valid_i && src_ready_o;
    assign tgt_valid_o = (count != '0);
    assign pop         = tgt_valid_o && tgt_ready_i;

    assign wr_ent.hold = src_last_i && (mode == MODE_THRU);
    assign wr_ent.last = src_last_i;
    assign wr_ent.data = src_data_i;

    wpb_fifo #(.DW(EW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (wr_ent),
        .pop   (pop),
        .dout  (rd_ent),
        .count (count)
    );

    assign tgt_data_o = rd_ent.data;
    assign tgt_last_o = rd_ent.last;

    wpb_mode_ctl #(.CW(CW)) u_mode (
        .clk       (clk),
        .rst       (rst),
        .post_en_i (post_en_i),
        .push      (push),
        .push_last (src_last_i),
        .count     (count),
        .mode      (mode),
        .in_burst  (in_burst)
    );

    assign xf.push      = push;
    assign xf.push_last = src_last_i;
    assign xf.pop       = pop;
    assign xf.pop_hold  = rd_ent.hold;

    wpb_done u_done (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .xf     (xf),
        .done_o (done_o)
    );

    p_thru_single_r5: assert property (@(posedge clk) disable iff (rst)
        (push && mode == MODE_THRU) |-> (count == '0));

    p_post_done_r3: assert property (@(posedge clk) disable iff (rst)
        (push && src_last_i && mode == MODE_POST) |=> done_o);

endmodule

// File: tb/wpost_buf_tb.sv
`timescale 1ns/1ps
module wpost_buf_tb;
    localparam int W     = 32;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic post_en_i = 1'b1;
    logic src_valid_i = 1'b0, src_last_i = 1'b0, tgt_ready_i = 1'b0;
    logic [W-1:0] src_data_i = '0;
    logic src_ready_o, done_o, tgt_valid_o, tgt_last_o;
    logic [W-1:0] tgt_data_o;

    always #5 clk = ~clk;

    wpost_buf #(.W(W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .post_en_i(post_en_i),
        .src_valid_i(src_valid_i), .src_ready_o(src_ready_o),
        .src_data_i(src_data_i), .src_last_i(src_last_i), .done_o(done_o),
        .tgt_valid_o(tgt_valid_o), .tgt_ready_i(tgt_ready_i),
        .tgt_data_o(tgt_data_o), .tgt_last_o(tgt_last_o)
    );

    int errors = 0, checks = 0;
    bit finished = 0;

    // bench reference state
    bit m_post = 1, m_inb = 0, m_done = 0;
    int m_cnt = 0;
    string m_done_req = "R8";
    logic [W+1:0] q[$];   // {hold, last, data}

    // stimulus state
    bit s_valid = 0, s_last = 0, t_rdy = 0, pe = 1;
    logic [W-1:0] s_data = '0;
    int left = 0;

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic bit exp_ready(input bit post, input int cnt);
        return post ? (cnt < DEPTH) : (cnt == 0);
    endfunction

    task automatic gen_src(input int prob);
        if (!s_valid && ($urandom % 100) < prob) begin
            s_valid = 1;
            s_data  = $urandom;
            if (left == 0) left = 1 + ($urandom % 5);
            s_last = (left == 1);
            left--;
        end
    endtask

    task automatic step();
        bit push, pop, nxt_post;
        logic [W+1:0] front;
        @(negedge clk);
        src_valid_i = s_valid; src_data_i = s_data; src_last_i = s_last;
        tgt_ready_i = t_rdy;   post_en_i = pe;
        #4;
        push = src_valid_i && src_ready_o;
        pop  = tgt_valid_o && tgt_ready_i;
        check("R4 tgt_valid", tgt_valid_o, (m_cnt != 0));
        check(m_post ? "R2 R7 src_ready" : "R5 R7 src_ready", src_ready_o, exp_ready(m_post, m_cnt));
        check(m_done_req, done_o, m_done);
        m_done = 0; m_done_req = "R8 spurious done";
        if (pop) begin
            front = q.pop_front();
            check("R4 data order", tgt_data_o, front[W-1:0]);
            check("R4 last flag", tgt_last_o, front[W]);
            if (front[W+1]) begin m_done = 1; m_done_req = "R6 thru done"; end
        end
        nxt_post = m_post;
        if (!m_inb && m_cnt == 0 && !push) nxt_post = pe;
        if (push) begin
            q.push_back({src_last_i && !m_post, src_last_i, src_data_i});
            if (src_last_i && m_post) begin m_done = 1; m_done_req = "R3 post done"; end
            m_inb = !src_last_i;
            s_valid = 0;
        end
        m_cnt = m_cnt + int'(push) - int'(pop);
        m_post = nxt_post;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        #4;
        check("R1 reset ready", src_ready_o, 1);
        check("R1 reset valid", tgt_valid_o, 0);
        check("R1 reset done", done_o, 0);
        @(negedge clk); rst = 1'b0;
        #4;
        check("R1 ready after reset", src_ready_o, 1);
        check("R1 valid after reset", tgt_valid_o, 0);

        // R2 R3: fill the buffer with a stalled target
        pe = 1; t_rdy = 0; left = 10;
        repeat (14) begin gen_src(100); step(); end
        check("R2 full count", m_cnt, DEPTH);
        check("R2 full stalls source", src_ready_o, 0);
        t_rdy = 1;
        repeat (14) begin gen_src(100); step(); end
        repeat (10) step();

        // R5 R6: pass-through, burst of three with throttled target
        pe = 0; t_rdy = 1;
        repeat (3) step();
        left = 3;
        repeat (40) begin gen_src(100); t_rdy = ($urandom % 100) < 50; step(); end
        t_rdy = 1;
        repeat (10) step();

        // R7: mode request lands mid-burst, posting with stalled target
        pe = 1; repeat (3) step();
        t_rdy = 0; left = 4;
        repeat (2) begin gen_src(100); step(); end
        pe = 0;
        repeat (4) begin gen_src(100); step(); end
        t_rdy = 1;
        repeat (20) step();

        // random posting, thru, and toggling phases
        pe = 1;
        repeat (1500) begin gen_src(70); t_rdy = ($urandom % 100) < 30; step(); end
        pe = 0;
        repeat (1500) begin gen_src(70); t_rdy = ($urandom % 100) < 50; step(); end
        repeat (3000) begin
            gen_src(80);
            t_rdy = ($urandom % 100) < 60;
            if (($urandom % 100) < 10) pe = !pe;
            step();
        end
        // finish any open burst and drain
        t_rdy = 1;
        while (left != 0 || s_valid) begin gen_src(100); step(); end
        repeat (20) step();
        check("R4 all words drained", q.size(), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule